// File: doc/BRIEF.md
# Bit-Sliced Four-Function ALU

This block is a purely combinational arithmetic/logic unit. It takes two operands and a three-bit operation code. It produces a result word and a carry-out. The unit is a chain of identical one-bit cells. Each cell holds a full adder, an AND gate and an OR gate, and a four-way selector picks among them. Carries travel from the least significant cell toward the most significant cell. The carry leaving the top cell is the unit's carry-out.

The operation codes are sparse. The two low code bits steer each cell's selector. The top code bit turns an addition into a subtraction: it inverts every cell's B input and injects a carry of one into the lowest cell. A code outside the defined four returns a result of zero and a carry of zero. The unit can sit in the execute stage of a datapath, or be used as a plain adder/subtractor with bitwise helpers.

Top module: `alu_ripple`

## Requirements
- R1: Code 3'b000 gives the bitwise AND of the operands, and the carry-out is 0.
- R2: Code 3'b001 gives the bitwise OR of the operands, and the carry-out is 0.
- R3: Code 3'b010 gives the low WIDTH bits of A+B as the result, and bit WIDTH of that sum as the carry-out.
- R4: Code 3'b110 gives A-B modulo 2^WIDTH. The carry-out is the carry of A + ~B + 1, which is 1 exactly when A >= B unsigned.
- R5: Codes 3'b011, 3'b100, 3'b101 and 3'b111 give a result of all zeros and a carry-out of 0, for any operands.
- R6: In a single cell under code 3'b010, the result bit is 1 when an odd number of a, b and carry-in are 1. The cell's carry-out is 1 when at least two of them are 1.
- R7: In a single cell under codes 3'b000 and 3'b001, the carry-in has no effect on the result bit, and the cell's carry-out is 0.
- R8: In a single cell under code 3'b110, the cell adds a, the inverse of b and the carry-in, with the sum and carry rules of R6.
- R9: Each cell's carry-out is the next higher cell's carry-in. An all-ones A plus 1 under code 3'b010 gives a result of 0 and a carry-out of 1.
- R10: Under code 3'b110, equal operands give 0 with a carry-out of 1. Zero minus one gives all ones with a carry-out of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand (inverted internally for subtraction) |
| op | input | 3 | Operation code |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry leaving the most significant cell |

## Verification
Immediate assertions are re-evaluated whenever the inputs change. In each cell they check the parity and majority laws of the adder, and that the logic codes produce no carry. At the top they check that the result and carry-out match the arithmetic sum or difference, the bitwise functions, and the all-zero answer for undefined codes. Two things only the bench's scenarios can show. The first is the full 64-entry behaviour of a standalone cell, including a carry-in under logic codes. The second is the ripple behaviour across the whole word, seen in the carry-propagating corner cases: all ones plus one, zero minus one, and equal operands.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110
    } alu_op_e;

    typedef struct packed {
        logic res;
        logic cout;
    } cell_out_t;

    function automatic logic op_defined(input logic [2:0] code);
        return (code == OP_AND) || (code == OP_OR) ||
               (code == OP_ADD) || (code == OP_SUB);
    endfunction
endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic sum,
    output logic cout
);
    always_comb begin
        sum  = x ^ y ^ cin;
        cout = (x & y) | (x & cin) | (y & cin);
    end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       cin,
    input  logic [2:0] op,
    output logic       r,
    output logic       cout
);
    logic      b_eff;
    logic      fa_sum;
    logic      fa_carry;
    cell_out_t cell_d;

    assign b_eff = b ^ op[2];

    alu_full_adder u_fa (
        .x    (a),
        .y    (b_eff),
        .cin  (cin),
        .sum  (fa_sum),
        .cout (fa_carry)
    );

    always_comb begin
        cell_d = '0;
        if (op_defined(op)) begin
            unique case (op[1:0])
                2'b00:   cell_d.res = a & b_eff;
                2'b01:   cell_d.res = a | b_eff;
                2'b10:   begin
                    cell_d.res  = fa_sum;
                    cell_d.cout = fa_carry;
                end
                default: cell_d.res = 1'b0;
            endcase
        end
    end

    assign r    = cell_d.res;
    assign cout = cell_d.cout;

    always_comb begin
        if (op == OP_ADD) begin
            p_cell_parity_r6: assert (r == (a ^ b ^ cin));
        end
        if (op == OP_AND || op == OP_OR) begin
            p_cell_nocarry_r7: assert (cout == 1'b0);
        end
        if (op == OP_SUB) begin
            p_cell_sub_majority_r8: assert (cout == ((a & ~b) | (a & cin) | (~b & cin)));
        end
    end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [2:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int CHAIN = WIDTH + 1;

    logic [CHAIN-1:0] carry_q;

    assign carry_q[0] = op[2];

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        alu_slice u_cell (
            .a    (opa[i]),
            .b    (opb[i]),
            .cin  (carry_q[i]),
            .op   (op),
            .r    (result[i]),
            .cout (carry_q[i+1])
        );
    end

    assign carry_out = carry_q[WIDTH];

    always_comb begin
        if (op == OP_AND) begin
            p_and_word_r1: assert (result == (opa & opb) && !carry_out);
        end
        if (op == OP_OR) begin
            p_or_word_r2: assert (result == (opa | opb) && !carry_out);
        end
        if (op == OP_ADD) begin
            p_add_word_r3: assert ({carry_out, result} == ({1'b0, opa} + {1'b0, opb}));
        end
        if (op == OP_SUB) begin
            p_sub_word_r4: assert (result == (opa - opb) && carry_out == (opa >= opb));
        end
        if (!op_defined(op)) begin
            p_bad_code_zero_r5: assert (result == '0 && !carry_out);
        end
    end
endmodule

// File: tb/alu_ripple_tb.sv
module alu_ripple_tb;
    localparam int W = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] a, b;
    logic [2:0]   op;
    logic [W-1:0] y;
    logic         co;

    logic s_a, s_b, s_c, s_r, s_co;
    logic [2:0] s_op;

    alu_ripple #(.WIDTH(W)) u_dut (
        .opa(a), .opb(b), .op(op), .result(y), .carry_out(co)
    );

    alu_slice u_cell (
        .a(s_a), .b(s_b), .cin(s_c), .op(s_op), .r(s_r), .cout(s_co)
    );

    function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] z,
                                         input logic [2:0] c);
        case (c)
            3'b000:  return {1'b0, x & z};
            3'b001:  return {1'b0, x | z};
            3'b010:  return {1'b0, x} + {1'b0, z};
            3'b110:  return {1'b0, x} + {1'b0, ~z} + 1;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic run32(input logic [W-1:0] x, input logic [W-1:0] z,
                         input logic [2:0] c, input string tag);
        logic [W:0] exp;
        @(posedge clk);
        a = x; b = z; op = c;
        @(negedge clk);
        exp = model(x, z, c);
        checks++;
        if ({co, y} !== exp) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h actual=%b_%h expected=%b_%h",
                     tag, c, x, z, co, y, exp[W], exp[W-1:0]);
        end
    endtask

    initial begin
        logic [W-1:0] corner [6];
        a = '0; b = '0; op = 3'b000;
        s_a = 0; s_b = 0; s_c = 0; s_op = 0;
        corner[0] = '0;            corner[1] = '1;
        corner[2] = 32'h0000_0001; corner[3] = 32'h8000_0000;
        corner[4] = 32'h7FFF_FFFF; corner[5] = 32'hAAAA_5555;

        // reset-state style check: all-zero inputs under AND (R1)
        run32('0, '0, 3'b000, "R1");

        // single-cell exhaustive sweep: bits {op[2:0], a, b, cin}
        for (int i = 0; i < 64; i++) begin
            logic e_r, e_c, bb;
            string tg;
            @(posedge clk);
            {s_op, s_a, s_b, s_c} = i[5:0];
            @(negedge clk);
            bb = s_b ^ s_op[2];
            e_r = 0; e_c = 0;
            case (s_op)
                3'b000: begin e_r = s_a & s_b; tg = "R7"; end
                3'b001: begin e_r = s_a | s_b; tg = "R7"; end
                3'b010: begin {e_c, e_r} = s_a + s_b + s_c; tg = "R6"; end
                3'b110: begin {e_c, e_r} = s_a + bb + s_c; tg = "R8"; end
                default: tg = "R5";
            endcase
            checks++;
            if ({s_co, s_r} !== {e_c, e_r}) begin
                errors++;
                $display("FAIL %s cell in=%b actual=%b%b expected=%b%b",
                         tg, i[5:0], s_co, s_r, e_c, e_r);
            end
        end

        // ripple corner cases
        run32('1, 32'd1, 3'b010, "R9");
        run32(32'd1, '1, 3'b010, "R9");
        run32(32'h1234_5678, 32'h1234_5678, 3'b110, "R10");
        run32('0, 32'd1, 3'b110, "R10");
        run32('1, '1, 3'b110, "R10");

        // every code over corner operand pairs
        for (int c = 0; c < 8; c++)
            for (int p = 0; p < 6; p++)
                for (int q = 0; q < 6; q++)
                    run32(corner[p], corner[q], c[2:0], tag_of(c[2:0]));

        // pseudo-random operands for every code
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] x, z;
            x = $urandom(); z = $urandom();
            if (n % 7 == 0) z = x;
            for (int c = 0; c < 8; c++)
                run32(x, z, c[2:0], tag_of(c[2:0]));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule